// File: doc/BRIEF.md
# PS/2 Keyboard Indicator Update Sequencer

This block updates the three lock indicators on a PS/2 keyboard from the host side. When a request is accepted, it captures the requested Scroll, Num and Caps lamp states. It then performs a two-step handshake on the keyboard's open-collector bus. First it sends the set-indicators command byte. It waits for the keyboard's acknowledge byte, and only then sends an argument byte that carries the lamp states. A second acknowledge ends the sequence with a one-cycle done strobe.

The block drives the bus clock and data lines only through pull-low enables. A separate frame receiver decodes the bytes that come back from the keyboard and hands them over as a valid strobe with a byte. Any fault ends the sequence with a one-cycle error strobe and releases the bus. A fault is a missing line acknowledge after a frame, an unexpected reply byte, or no reply within the timeout window. No retry is made.

Top module: `ps2_led_seq`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low and both pull-low enables are off, and they stay so until a request arrives.
- R2: The first byte sent is 0xED. A frame is a start bit 0, eight data bits least significant first, an odd parity bit (the nine bits after the start bit hold an odd number of ones) and a stop bit 1. The stop bit is sent by releasing the data line.
- R3: Before each byte, the host holds the clock line low for at least INHIBIT_CYC cycles. It then pulls data low as the start bit while the clock is still low, and then releases the clock.
- R4: While a frame is sent, the data enable changes only while the keyboard holds the clock line low. Bit k of the frame (start bit = bit 0) is driven after the k-th falling clock edge produced by the keyboard.
- R5: The second byte is sent only after reply 0xFA. Its bit 0 is Scroll Lock (led_i[0]), bit 1 is Num Lock (led_i[1]) and bit 2 is Caps Lock (led_i[2]). Bits 7..3 are 0.
- R6: Reply 0xFA to the second byte gives one done_o pulse of one cycle. busy_o falls in the same cycle.
- R7: If the data line is not low at the keyboard's 11th falling clock edge of a frame, err_o pulses and the sequence ends.
- R8: A reply byte other than 0xFA, in either wait phase, gives an err_o pulse, and no further byte is sent.
- R9: If 0xFA has not arrived TIMEOUT_CYC cycles after a byte's send begins, err_o pulses, the bus is released and busy_o falls.
- R10: A request made while busy_o is high is ignored. The lamp states used are those present in the cycle the request was accepted.
- R11: busy_o is high from the cycle after an accepted request until the ending strobe. done_o and err_o are never high together.
- R12: Received bytes that arrive while idle cause no strobe and no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe to update the indicators |
| led_i | input | 3 | Lamp states: [0] Scroll, [1] Num, [2] Caps |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | One-cycle pulse on failure |
| ps2_clk_i | input | 1 | Level of the bus clock line |
| ps2_dat_i | input | 1 | Level of the bus data line |
| ps2_clk_oe_o | output | 1 | Pull the bus clock line low when 1 |
| ps2_dat_oe_o | output | 1 | Pull the bus data line low when 1 |
| rx_valid_i | input | 1 | Received byte strobe from the frame receiver |
| rx_byte_i | input | 8 | Received byte |

## Verification
The bench builds the block with INHIBIT_CYC = 40 and TIMEOUT_CYC = 1500 instead of the real-time defaults (100 µs and 20 ms at 250 MHz). Several complete sequences with a modelled keyboard therefore fit in a short run. The reply timeout can be hit and its firing cycle bracketed, and the pre-start hold can be measured against its bound. SYNC_STAGES stays at 2, so the keyboard model's clock half-period of 10 cycles leaves the synchronizer latency well inside each phase.

// File: rtl/ps2_led_pkg.sv
package ps2_led_pkg;

   localparam logic [7:0] KB_CMD_SETIND = 8'hED;
   localparam logic [7:0] KB_REPLY_OK   = 8'hFA;
   localparam int         FRAME_BITS    = 11;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_SEND_CMD,
      SQ_WAIT_CMD,
      SQ_SEND_ARG,
      SQ_WAIT_ARG
   } seq_state_t;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_INHIBIT,
      TX_START,
      TX_SHIFT
   } tx_state_t;

   // frame[0] start, [8:1] data LSB first, [9] odd parity, [10] stop
   function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] d);
      return {1'b1, ~(^d), d, 1'b0};
   endfunction

   function automatic logic [7:0] lamp_arg(input logic [2:0] lamps);
      return {5'b00000, lamps};
   endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ps2_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[STAGES-2:0], line_i};
   end

   assign line_o = sh_q[STAGES-1];

endmodule

// File: rtl/ps2_led_timer.sv
module ps2_led_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic run_i,
   output logic expired_o
);

   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("ps2_led_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (clear_i)                   cnt_q <= '0;
      else if (run_i && !expired_o)       cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = (cnt_q == CW'(LIMIT));

   // expiry only follows a cycle in which the timer was counting (R9)
   p_expire_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired_o) |-> $past(run_i));

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
   import ps2_led_pkg::*;
#(
   parameter int INHIBIT_CYC = 25000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [7:0] byte_i,
   input  logic       abort_i,
   input  logic       clk_line_i,
   input  logic       dat_line_i,
   output logic       clk_oe_o,
   output logic       dat_oe_o,
   output logic       sent_o,
   output logic       nack_o
);

   localparam int ICW = $clog2(INHIBIT_CYC + 1);

   generate
      if (INHIBIT_CYC < 1) begin : g_bad_inhibit
         $error("ps2_host_tx: INHIBIT_CYC must be positive");
      end
   endgenerate

   tx_state_t             state_q;
   logic [ICW-1:0]        icnt_q;
   logic [FRAME_BITS-1:0] frame_q;
   logic [3:0]            bitn_q;
   logic                  clk_s, dat_s, clk_prev_q;
   logic                  fall;

   ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .line_i(clk_line_i), .line_o(clk_s));
   ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .line_i(dat_line_i), .line_o(dat_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev_q <= 1'b1;
      else        clk_prev_q <= clk_s;
   end

   assign fall = clk_prev_q & ~clk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= TX_IDLE;
         icnt_q   <= '0;
         frame_q  <= '1;
         bitn_q   <= '0;
         clk_oe_o <= 1'b0;
         dat_oe_o <= 1'b0;
         sent_o   <= 1'b0;
         nack_o   <= 1'b0;
      end else begin
         sent_o <= 1'b0;
         nack_o <= 1'b0;
         if (abort_i) begin
            state_q  <= TX_IDLE;
            clk_oe_o <= 1'b0;
            dat_oe_o <= 1'b0;
         end else begin
            unique case (state_q)
               TX_IDLE: begin
                  if (start_i) begin
                     frame_q  <= build_frame(byte_i);
                     icnt_q   <= '0;
                     clk_oe_o <= 1'b1;
                     dat_oe_o <= 1'b0;
                     state_q  <= TX_INHIBIT;
                  end
               end
               TX_INHIBIT: begin
                  icnt_q <= icnt_q + 1'b1;
                  if (icnt_q == ICW'(INHIBIT_CYC - 1)) begin
                     dat_oe_o <= ~frame_q[0];
                     state_q  <= TX_START;
                  end
               end
               TX_START: begin
                  clk_oe_o <= 1'b0;
                  bitn_q   <= '0;
                  state_q  <= TX_SHIFT;
               end
               TX_SHIFT: begin
                  if (fall) begin
                     bitn_q <= bitn_q + 1'b1;
                     if (bitn_q < 4'd10) begin
                        dat_oe_o <= ~frame_q[bitn_q + 4'd1];
                     end else begin
                        dat_oe_o <= 1'b0;
                        if (!dat_s) sent_o <= 1'b1;
                        else        nack_o <= 1'b1;
                        state_q <= TX_IDLE;
                     end
                  end
               end
               default: state_q <= TX_IDLE;
            endcase
         end
      end
   end

   // data enable moves only after a cycle with the keyboard clock seen low (R4)
   p_data_moves_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(dat_oe_o) && $past(state_q) == TX_SHIFT) |-> !$past(clk_s));

   // the start bit is only put on the line while the clock is held low (R3)
   p_start_under_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_START) |-> (clk_oe_o && dat_oe_o));

   p_ack_outcome_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(sent_o && nack_o));

endmodule

// File: rtl/ps2_led_seq.sv
module ps2_led_seq
   import ps2_led_pkg::*;
#(
   parameter int INHIBIT_CYC = 25000,
   parameter int TIMEOUT_CYC = 5000000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_i,
   input  logic [2:0] led_i,
   output logic       busy_o,
   output logic       done_o,
   output logic       err_o,
   input  logic       ps2_clk_i,
   input  logic       ps2_dat_i,
   output logic       ps2_clk_oe_o,
   output logic       ps2_dat_oe_o,
   input  logic       rx_valid_i,
   input  logic [7:0] rx_byte_i
);

   generate
      if (TIMEOUT_CYC <= 2 * INHIBIT_CYC) begin : g_bad_timeout
         $error("ps2_led_seq: TIMEOUT_CYC must exceed twice INHIBIT_CYC");
      end
   endgenerate

   seq_state_t state_q;
   logic [2:0] lamps_q;
   logic       tx_go_q;
   logic [7:0] tx_byte_q;
   logic       tx_sent, tx_nack, tx_abort;
   logic       tmr_clr, tmr_exp;
   logic       accept, ok_reply_cmd;
   logic       sending;

   assign accept       = (state_q == SQ_IDLE) && req_i;
   assign ok_reply_cmd = (state_q == SQ_WAIT_CMD) && rx_valid_i &&
                         (rx_byte_i == KB_REPLY_OK) && !tmr_exp;
   assign tmr_clr      = accept || ok_reply_cmd;
   assign sending      = (state_q == SQ_SEND_CMD) || (state_q == SQ_SEND_ARG);
   assign tx_abort     = sending && tmr_exp;
   assign busy_o       = (state_q != SQ_IDLE);

   ps2_led_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear_i(tmr_clr), .run_i(busy_o),
      .expired_o(tmr_exp));

   ps2_host_tx #(.INHIBIT_CYC(INHIBIT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_tx (
      .clk(clk), .rst_n(rst_n), .start_i(tx_go_q), .byte_i(tx_byte_q),
      .abort_i(tx_abort), .clk_line_i(ps2_clk_i), .dat_line_i(ps2_dat_i),
      .clk_oe_o(ps2_clk_oe_o), .dat_oe_o(ps2_dat_oe_o),
      .sent_o(tx_sent), .nack_o(tx_nack));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         lamps_q   <= '0;
         tx_go_q   <= 1'b0;
         tx_byte_q <= '0;
         done_o    <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         tx_go_q <= 1'b0;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
         unique case (state_q)
            SQ_IDLE: begin
               if (req_i) begin
                  lamps_q   <= led_i;
                  tx_byte_q <= KB_CMD_SETIND;
                  tx_go_q   <= 1'b1;
                  state_q   <= SQ_SEND_CMD;
               end
            end
            SQ_SEND_CMD, SQ_SEND_ARG: begin
               if (tx_nack || tmr_exp) begin
                  err_o   <= 1'b1;
                  state_q <= SQ_IDLE;
               end else if (tx_sent) begin
                  state_q <= (state_q == SQ_SEND_CMD) ? SQ_WAIT_CMD : SQ_WAIT_ARG;
               end
            end
            SQ_WAIT_CMD: begin
               if (tmr_exp) begin
                  err_o   <= 1'b1;
                  state_q <= SQ_IDLE;
               end else if (rx_valid_i) begin
                  if (rx_byte_i == KB_REPLY_OK) begin
                     tx_byte_q <= lamp_arg(lamps_q);
                     tx_go_q   <= 1'b1;
                     state_q   <= SQ_SEND_ARG;
                  end else begin
                     err_o   <= 1'b1;
                     state_q <= SQ_IDLE;
                  end
               end
            end
            SQ_WAIT_ARG: begin
               if (tmr_exp) begin
                  err_o   <= 1'b1;
                  state_q <= SQ_IDLE;
               end else if (rx_valid_i) begin
                  if (rx_byte_i == KB_REPLY_OK) done_o <= 1'b1;
                  else                          err_o  <= 1'b1;
                  state_q <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   p_bus_released_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!ps2_clk_oe_o && !ps2_dat_oe_o));

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_busy_ends_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (done_o || err_o));

   p_lamps_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && req_i) |=> $stable(lamps_q));

   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   p_idle_rx_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !req_i) |=> (!done_o && !err_o && !busy_o));

endmodule

// File: tb/ps2_led_seq_bench.sv
module ps2_led_seq_bench;

   localparam int INHIBIT = 40;
   localparam int TMO     = 1500;
   localparam int HALF    = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic [2:0] leds = '0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       kbd_clk_low = 1'b0;
   logic       kbd_dat_low = 1'b0;
   logic       busy, done, err, clk_oe, dat_oe;
   wire        line_clk = ~(clk_oe | kbd_clk_low);
   wire        line_dat = ~(dat_oe | kbd_dat_low);

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int done_cnt = 0;
   int err_cnt = 0;
   int err_at = 0;
   int run_len = 0;
   int last_run = 0;
   int r4_viol = 0;
   int req_at = 0;
   logic in_frame = 1'b0;
   logic prev_dat_oe = 1'b0;

   always #2 clk = ~clk;

   ps2_led_seq #(.INHIBIT_CYC(INHIBIT), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u_ps2_led_seq (
      .clk(clk), .rst_n(rst_n), .req_i(req), .led_i(leds),
      .busy_o(busy), .done_o(done), .err_o(err),
      .ps2_clk_i(line_clk), .ps2_dat_i(line_dat),
      .ps2_clk_oe_o(clk_oe), .ps2_dat_oe_o(dat_oe),
      .rx_valid_i(rx_valid), .rx_byte_i(rx_byte));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (done) done_cnt <= done_cnt + 1;
      if (err) begin err_cnt <= err_cnt + 1; err_at <= cyc; end
      if (clk_oe) run_len <= run_len + 1;
      else begin
         if (run_len != 0) last_run <= run_len;
         run_len <= 0;
      end
      prev_dat_oe <= dat_oe;
      if (in_frame && line_clk && !kbd_clk_low && (dat_oe != prev_dat_oe) && !clk_oe)
         r4_viol <= r4_viol + 1;
   end

   task automatic check(input logic cond, input string rq, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic pulse_req(input logic [2:0] l);
      @(negedge clk);
      leds = l; req = 1'b1; req_at = cyc;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic send_rx(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   function automatic logic [7:0] exp_arg(input logic [2:0] l);
      return {5'b00000, l[2], l[1], l[0]};
   endfunction

   // keyboard side of a host-to-device frame
   task automatic kbd_receive(input logic give_ack, input int limit,
                              output logic [7:0] b, output logic fr_ok, output logic got);
      logic [9:0] sh;
      int w;
      got = 1'b0; b = '0; fr_ok = 1'b0; sh = '0;
      w = 0;
      while (!(clk_oe == 1'b0 && dat_oe == 1'b1) && w < limit) begin
         @(negedge clk); w++;
      end
      if (w >= limit) return;
      got = 1'b1;
      in_frame = 1'b1;
      repeat (8) @(negedge clk);
      for (int i = 0; i < 10; i++) begin
         kbd_clk_low = 1'b1;
         repeat (HALF) @(negedge clk);
         kbd_clk_low = 1'b0;
         repeat (2) @(negedge clk);
         sh[i] = line_dat;
         repeat (HALF - 2) @(negedge clk);
      end
      if (give_ack) kbd_dat_low = 1'b1;
      repeat (3) @(negedge clk);
      kbd_clk_low = 1'b1;
      repeat (HALF) @(negedge clk);
      kbd_clk_low = 1'b0;
      repeat (HALF) @(negedge clk);
      kbd_dat_low = 1'b0;
      in_frame = 1'b0;
      b = sh[7:0];
      fr_ok = (^sh[8:0] == 1'b1) && sh[9];
   endtask

   task automatic wait_strobe(input int limit, input int d0, input int e0);
      int w;
      w = 0;
      while (done_cnt == d0 && err_cnt == e0 && w < limit) begin
         @(negedge clk); w++;
      end
      @(negedge clk);
   endtask

   // mode 0 good, 1 bad reply, 2 no reply, 3 no line ack
   task automatic run_seq(input logic [2:0] l, input int mode, input logic poke, input int dly);
      logic [7:0] b;
      logic ok, got;
      int d0, e0;
      d0 = done_cnt; e0 = err_cnt;
      pulse_req(l);
      check(busy == 1'b1, "R11 busy after accept", busy, 1);
      kbd_receive(mode != 3, 3000, b, ok, got);
      check(got && b == 8'hED, "R2 command byte", b, 8'hED);
      check(ok, "R2 parity/stop", ok, 1);
      check(last_run >= INHIBIT, "R3 clock hold before start", last_run, INHIBIT);
      if (poke) pulse_req(~l);
      if (mode == 3) begin
         wait_strobe(200, d0, e0);
         check(err_cnt == e0 + 1 && done_cnt == d0, "R7 missing line ack", err_cnt - e0, 1);
         check(!busy && !clk_oe && !dat_oe, "R7 bus released", {busy, clk_oe, dat_oe}, 0);
         return;
      end
      repeat (dly) @(negedge clk);
      if (mode == 1) begin
         send_rx(8'hFE);
         wait_strobe(50, d0, e0);
         check(err_cnt == e0 + 1, "R8 bad reply error", err_cnt - e0, 1);
         kbd_receive(1'b1, 600, b, ok, got);
         check(!got, "R8 no second byte", got, 0);
         return;
      end
      if (mode == 2) begin
         wait_strobe(TMO + 200, d0, e0);
         check(err_cnt == e0 + 1 && done_cnt == d0, "R9 timeout error", err_cnt - e0, 1);
         check((err_at - req_at) >= TMO && (err_at - req_at) <= TMO + 6,
               "R9 timeout cycle", err_at - req_at, TMO);
         check(!busy && !clk_oe, "R9 released", {busy, clk_oe}, 0);
         return;
      end
      send_rx(8'hFA);
      kbd_receive(1'b1, 3000, b, ok, got);
      check(got && b == exp_arg(l), "R5 lamp byte", b, exp_arg(l));
      check(ok, "R5 lamp frame parity", ok, 1);
      repeat (dly) @(negedge clk);
      send_rx(8'hFA);
      wait_strobe(30, d0, e0);
      check(done_cnt == d0 + 1 && err_cnt == e0, "R6 done pulse", done_cnt - d0, 1);
      check(!busy, "R6 busy cleared", busy, 0);
      if (poke) begin
         kbd_receive(1'b1, 400, b, ok, got);
         check(!got && done_cnt == d0 + 1, "R10 busy request ignored", got, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R11 watchdog expired: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(!busy && !done && !err && !clk_oe && !dat_oe, "R1 reset state",
            {busy, done, err, clk_oe, dat_oe}, 0);

      send_rx(8'hFA);
      send_rx(8'h12);
      repeat (40) @(negedge clk);
      check(done_cnt == 0 && err_cnt == 0 && !busy && !clk_oe, "R12 idle rx ignored",
            done_cnt + err_cnt, 0);

      run_seq(3'b001, 0, 1'b0, 20);
      run_seq(3'b010, 0, 1'b0, 25);
      run_seq(3'b100, 0, 1'b0, 30);
      run_seq(3'b101, 0, 1'b1, 30);
      for (int k = 0; k < 6; k++) begin
         run_seq(3'($urandom_range(0, 7)), 0, 1'($urandom_range(0, 1)),
                 int'($urandom_range(5, 80)));
      end
      run_seq(3'b111, 1, 1'b0, 30);
      run_seq(3'b011, 2, 1'b0, 30);
      run_seq(3'b110, 3, 1'b0, 30);
      run_seq(3'b000, 0, 1'b0, 15);

      check(r4_viol == 0, "R4 data moved with clock high", r4_viol, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule